// File: doc/BRIEF.md
# Shared Write-Synchronizer Register Bridge

This block sits between a register bus running on the bus clock and a register file running on a peripheral core clock. It holds the bus-side copy of every register of one peripheral. Registers flagged as write-synchronized are also forwarded to the core domain. The forwarding goes through a single toggle handshake, which all synchronized registers share. While a forwarded write is in flight, a busy flag is raised. Any further bus write is held off with a low ready until the core domain has acknowledged the transfer. The handshake always runs, even when both clocks come from the same source.

An interface clock enable gates access to the peripheral. While it is low, every read returns zero and every write is accepted at once and thrown away. Software learns that a synchronized write has finished by polling the busy bit in the status register. Reads, including status reads, are never held off.

The register map has 2^ADDR_W words. Address 0 is the read-only status word, with busy in bit 0. A parameter mask selects which of the other addresses are write-synchronized. By default these are addresses 1, 2 and 3, while addresses 4 to 7 are direct registers.

Top module: `wsync_bridge`

## Requirements
- R1: After reset, busy is 0, the status word reads 0 and every register reads 0.
- R2: A write to a synchronized address (1, 2 or 3) that is accepted on a bus edge makes busy read 1 from the next bus cycle on.
- R3: Each accepted synchronized write produces exactly one single-cycle coreWrEn pulse in the core domain, carrying the written address and data.
- R4: Busy returns to 0 by itself within 20 bus cycles of the accepted synchronized write, once the acknowledge has come back.
- R5: While busy is 1, any bus write (to a synchronized or direct address) sees reqReady low and is accepted only after busy clears, after which it takes effect.
- R6: A write to a direct address (4 to 7) completes in the cycle it is presented, leaves busy at 0 and causes no core pulse, and a later read returns the written value.
- R7: Reads are never stalled. A read of address 0 while a transfer is pending returns 1 in bit 0 in the same cycle.
- R8: While clkEn is 0, every read returns 0, and every write is accepted without stall and discarded: no register changes, busy stays 0 and no core pulse occurs.
- R9: With the core clock driven by the bus clock itself, a synchronized write still raises busy, still reaches the core domain and still clears within 20 bus cycles.
- R10: A write to address 0 is ignored: busy stays 0, the status word reads 0 and no core pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| busRstN | input | 1 | Bus-side active-low asynchronous reset |
| coreClk | input | 1 | Peripheral core clock |
| coreRstN | input | 1 | Core-side active-low asynchronous reset |
| clkEn | input | 1 | Interface clock enable; low blocks access |
| reqValid | input | 1 | Bus request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Register word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| rspRdata | output | DATA_W | Read data, valid in the cycle the read is accepted |
| busy | output | 1 | Synchronized write in flight |
| regQ | output | 2^ADDR_W*DATA_W | Bus-side register contents, word i at bits i*DATA_W |
| coreWrEn | output | 1 | Single-cycle core-domain write strobe |
| coreWrAddr | output | ADDR_W | Core-domain write address |
| coreWrData | output | DATA_W | Core-domain write data |

## Verification
A new bus request can arrive in the same cycle as the pending transfer finishes, so the stall logic and the busy clear can meet in one cycle. The bench provokes this by issuing a write straight after a synchronized write. That write is held with reqReady low for some cycles, is accepted just as busy falls, and then must deliver a second, correct core pulse. In the same window a status read is issued. It must complete at once and report busy, so a read and the pending handshake also share a cycle. The bench judges both cases by the stall count, the read value and the core-side address and data it records.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  typedef struct packed {
    logic shadowWe;  // update bus-side copy of the addressed register
    logic holdLoad;  // capture address/data for the core transfer
    logic rdStatus;  // read mux selects the status word
    logic rdZero;    // read mux forced to zero (access blocked)
  } wsStrobe_t;
endpackage

// File: rtl/wsyncCtrl.sv
module wsyncCtrl
  import wsync_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int STATUS_ADDR = 0,
  parameter logic [(1<<ADDR_W)-1:0] SYNC_MASK = '0
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              clkEn,
  input  logic              ackTgl,
  output logic              reqReady,
  output logic              busy,
  output logic              reqTgl,
  output wsStrobe_t         stb
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

  logic ackS1, ackS2;
  logic isSync, isStatus, wrStall, accept;

  assign isSync   = SYNC_MASK[reqAddr];
  assign isStatus = (reqAddr == STAT_A);
  assign wrStall  = reqValid && reqWrite && clkEn && busy;
  assign reqReady = !wrStall;
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb.shadowWe = accept && reqWrite && clkEn && !isStatus;
    stb.holdLoad = accept && reqWrite && clkEn && !isStatus && isSync;
    stb.rdStatus = isStatus;
    stb.rdZero   = !clkEn;
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTgl <= 1'b0;
      ackS1  <= 1'b0;
      ackS2  <= 1'b0;
    end else begin
      ackS1 <= ackTgl;
      ackS2 <= ackS1;
      if (stb.holdLoad) reqTgl <= !reqTgl;
    end
  end

  assign busy = reqTgl ^ ackS2;

  assert_write_stall_R5: assert property (@(posedge busClk) disable iff (!busRstN)
    (busy && clkEn && reqValid && reqWrite) |-> !reqReady);
  assert_busy_set_R2: assert property (@(posedge busClk) disable iff (!busRstN)
    stb.holdLoad |=> busy);
  assert_read_ready_R7: assert property (@(posedge busClk) disable iff (!busRstN)
    (reqValid && !reqWrite) |-> reqReady);
  assert_mask_blocks_R8: assert property (@(posedge busClk) disable iff (!busRstN)
    !clkEn |-> (!stb.shadowWe && !stb.holdLoad));
  assert_direct_nobusy_R6: assert property (@(posedge busClk) disable iff (!busRstN)
    (stb.shadowWe && !stb.holdLoad && !busy) |=> !busy);
endmodule

// File: rtl/wsyncDatapath.sv
module wsyncDatapath
  import wsync_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int STATUS_ADDR = 0
) (
  input  logic                             busClk,
  input  logic                             busRstN,
  input  wsStrobe_t                        stb,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [DATA_W-1:0]                reqWdata,
  input  logic                             busy,
  output logic [DATA_W-1:0]                rspRdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    regQ,
  output logic [ADDR_W-1:0]                holdAddr,
  output logic [DATA_W-1:0]                holdData
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] shadow [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    if (i == STATUS_ADDR) begin : gStat
      assign shadow[i] = '0;
    end else begin : gStore
      logic [DATA_W-1:0] q;
      always_ff @(posedge busClk or negedge busRstN) begin
        if (!busRstN) q <= '0;
        else if (stb.shadowWe && reqAddr == ADDR_W'(i)) q <= reqWdata;
      end
      assign shadow[i] = q;
    end
    assign regQ[i*DATA_W +: DATA_W] = shadow[i];
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      holdAddr <= '0;
      holdData <= '0;
    end else if (stb.holdLoad) begin
      holdAddr <= reqAddr;
      holdData <= reqWdata;
    end
  end

  always_comb begin
    if (stb.rdZero)        rspRdata = '0;
    else if (stb.rdStatus) rspRdata = {{(DATA_W-1){1'b0}}, busy};
    else                   rspRdata = shadow[reqAddr];
  end

  assert_hold_stable_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    busy |=> ($stable(holdAddr) && $stable(holdData)));
endmodule

// File: rtl/wsyncCore.sv
module wsyncCore #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic              reqTgl,
  input  logic [ADDR_W-1:0] holdAddr,
  input  logic [DATA_W-1:0] holdData,
  output logic              ackTgl,
  output logic              coreWrEn,
  output logic [ADDR_W-1:0] coreWrAddr,
  output logic [DATA_W-1:0] coreWrData
);
  logic reqS1, reqS2, reqS3, newReq;

  assign newReq = reqS2 ^ reqS3;

  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      reqS1      <= 1'b0;
      reqS2      <= 1'b0;
      reqS3      <= 1'b0;
      coreWrEn   <= 1'b0;
      coreWrAddr <= '0;
      coreWrData <= '0;
    end else begin
      reqS1    <= reqTgl;
      reqS2    <= reqS1;
      reqS3    <= reqS2;
      coreWrEn <= newReq;
      if (newReq) begin
        coreWrAddr <= holdAddr;
        coreWrData <= holdData;
      end
    end
  end

  assign ackTgl = reqS3;

  assert_single_pulse_R3: assert property (@(posedge coreClk) disable iff (!coreRstN)
    coreWrEn |=> !coreWrEn);
endmodule

// File: rtl/wsync_bridge.sv
module wsync_bridge
  import wsync_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int STATUS_ADDR = 0,
  parameter logic [(1<<ADDR_W)-1:0] SYNC_MASK = 8'b0000_1110
) (
  input  logic                          busClk,
  input  logic                          busRstN,
  input  logic                          coreClk,
  input  logic                          coreRstN,
  input  logic                          clkEn,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  output logic                          reqReady,
  output logic [DATA_W-1:0]             rspRdata,
  output logic                          busy,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regQ,
  output logic                          coreWrEn,
  output logic [ADDR_W-1:0]             coreWrAddr,
  output logic [DATA_W-1:0]             coreWrData
);
  wsStrobe_t         stb;
  logic              reqTgl, ackTgl;
  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;

  wsyncCtrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .SYNC_MASK(SYNC_MASK)) uCtrl (
    .busClk(busClk), .busRstN(busRstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .clkEn(clkEn), .ackTgl(ackTgl), .reqReady(reqReady),
    .busy(busy), .reqTgl(reqTgl), .stb(stb));

  wsyncDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)) uDp (
    .busClk(busClk), .busRstN(busRstN), .stb(stb), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busy(busy), .rspRdata(rspRdata), .regQ(regQ),
    .holdAddr(holdAddr), .holdData(holdData));

  wsyncCore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCore (
    .coreClk(coreClk), .coreRstN(coreRstN), .reqTgl(reqTgl), .holdAddr(holdAddr),
    .holdData(holdData), .ackTgl(ackTgl), .coreWrEn(coreWrEn),
    .coreWrAddr(coreWrAddr), .coreWrData(coreWrData));
endmodule

// File: tb/sim_wsync_bridge.sv
`timescale 1ns/1ps
module sim_wsync_bridge;
  localparam int AW = 3;
  localparam int DW = 16;

  logic busClk = 0, altClk = 0, sameClk = 0, rstN = 0;
  logic coreClk;
  logic clkEn = 1, reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, busy, coreWrEn;
  logic [DW-1:0] rspRdata, coreWrData;
  logic [AW-1:0] coreWrAddr;
  logic [(1<<AW)*DW-1:0] regQ;

  int errors = 0, checks = 0;
  int coreCount = 0;
  logic [AW-1:0] lastA = '0;
  logic [DW-1:0] lastD = '0;

  always #10 busClk = ~busClk;
  always #7 altClk = ~altClk;
  assign coreClk = sameClk ? busClk : altClk;

  wsync_bridge u0 (
    .busClk(busClk), .busRstN(rstN), .coreClk(coreClk), .coreRstN(rstN),
    .clkEn(clkEn), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady), .rspRdata(rspRdata), .busy(busy),
    .regQ(regQ), .coreWrEn(coreWrEn), .coreWrAddr(coreWrAddr), .coreWrData(coreWrData));

  always @(negedge coreClk) if (coreWrEn) begin
    coreCount++;
    lastA = coreWrAddr;
    lastD = coreWrData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
    stalls = 0;
    @(negedge busClk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    #1;
    while (!reqReady && stalls < 100) begin
      stalls++;
      @(negedge busClk); #1;
    end
    @(negedge busClk);
    reqValid = 0; reqWrite = 0;
    #1;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [DW-1:0] d, output int waits);
    waits = 0;
    @(negedge busClk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    #1;
    while (!reqReady && waits < 100) begin
      waits++;
      @(negedge busClk); #1;
    end
    d = rspRdata;
    @(negedge busClk);
    reqValid = 0;
    #1;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 60) begin
      @(negedge busClk); #1;
      cyc++;
    end
  endtask

  task automatic testReset();
    logic [DW-1:0] d; int w;
    check(busy == 0, "R1 busy", busy, 0);
    busRead(0, d, w); check(d == 0, "R1 status", d, 0);
    busRead(5, d, w); check(d == 0, "R1 reg5", d, 0);
  endtask

  task automatic testDirect();
    logic [DW-1:0] d; int s, w, c0;
    c0 = coreCount;
    busWrite(5, 16'h1234, s);
    check(s == 0, "R6 no stall", s, 0);
    check(busy == 0, "R6 no busy", busy, 0);
    busRead(5, d, w); check(d == 16'h1234, "R6 readback", d, 16'h1234);
    repeat (10) @(negedge busClk);
    check(coreCount == c0, "R6 no core pulse", coreCount, c0);
  endtask

  task automatic testSync();
    int s, cyc, c0;
    c0 = coreCount;
    busWrite(2, 16'hBEEF, s);
    check(busy == 1, "R2 busy set", busy, 1);
    waitIdle(cyc);
    check(cyc <= 20, "R4 busy clears", cyc, 20);
    @(negedge busClk);
    check(coreCount == c0 + 1, "R3 one pulse", coreCount, c0 + 1);
    check(lastA == 2 && lastD == 16'hBEEF, "R3 core data", lastD, 16'hBEEF);
  endtask

  task automatic testStall();
    logic [DW-1:0] d; int s, w, cyc, c0;
    c0 = coreCount;
    busWrite(1, 16'h0A0A, s);
    busRead(0, d, w);
    check(w == 0 && d == 1, "R7 status read while busy", d, 1);
    busWrite(3, 16'h3333, s);
    check(s > 0, "R5 sync write stalled", s, 1);
    waitIdle(cyc);
    repeat (4) @(negedge busClk);
    check(coreCount == c0 + 2, "R5 both writes delivered", coreCount, c0 + 2);
    check(lastA == 3 && lastD == 16'h3333, "R5 second write data", lastD, 16'h3333);
    busWrite(1, 16'h0B0B, s);
    busWrite(6, 16'h6666, s);
    check(s > 0, "R5 direct write stalled", s, 1);
    busRead(6, d, w);
    check(d == 16'h6666, "R5 direct write landed", d, 16'h6666);
    waitIdle(cyc);
  endtask

  task automatic testMask();
    logic [DW-1:0] d; int s, w, c0;
    c0 = coreCount;
    clkEn = 0;
    busRead(5, d, w); check(d == 0, "R8 masked read", d, 0);
    busWrite(5, 16'hFFFF, s); check(s == 0, "R8 no stall", s, 0);
    busWrite(1, 16'h1111, s);
    check(busy == 0, "R8 no busy", busy, 0);
    repeat (10) @(negedge busClk);
    check(coreCount == c0, "R8 no core pulse", coreCount, c0);
    clkEn = 1;
    busRead(5, d, w); check(d == 16'h1234, "R8 write discarded", d, 16'h1234);
  endtask

  task automatic testStatusWrite();
    logic [DW-1:0] d; int s, w, c0;
    c0 = coreCount;
    busWrite(0, 16'hFFFF, s);
    check(busy == 0, "R10 no busy", busy, 0);
    busRead(0, d, w); check(d == 0, "R10 status unchanged", d, 0);
    repeat (10) @(negedge busClk);
    check(coreCount == c0, "R10 no core pulse", coreCount, c0);
  endtask

  task automatic testSameClock();
    int s, cyc, c0;
    sameClk = 1;
    repeat (4) @(negedge busClk);
    c0 = coreCount;
    busWrite(3, 16'h5A5A, s);
    check(busy == 1, "R9 busy set", busy, 1);
    waitIdle(cyc);
    check(cyc <= 20, "R9 busy clears", cyc, 20);
    @(negedge busClk);
    check(coreCount == c0 + 1 && lastD == 16'h5A5A, "R9 core write", lastD, 16'h5A5A);
    sameClk = 0;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge busClk);
    rstN = 1;
    repeat (2) @(negedge busClk);
    testReset();
    testDirect();
    testSync();
    testStall();
    testMask();
    testStatusWrite();
    testSameClock();
    repeat (5) @(negedge busClk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule